// File: doc/BRIEF.md
# Asynchronous SRAM access controller

This block sits between a clocked requester and a 128K x 8 asynchronous static RAM. The requester presents one word at a time: a level `req` with a direction bit, a 17-bit word address and, for writes, one data byte. The controller registers the address and data when it takes the request. It then drives the two chip enables (one active low, one active high), the output enable and the write enable in a fixed sequence. When the access is over it raises `ack` for one cycle. On a read, the captured byte is returned on `rd_data` in that same cycle.

Every phase length is given in nanoseconds as a parameter and turned into a whole number of clock cycles against `CLK_PERIOD_NS`. The conversion rounds up and never yields less than one cycle. After reset the chip stays deselected for a long hold interval, so that the memory can leave its low-voltage retention state before any access. After every read the controller leaves the bus idle long enough for the memory's output drivers to switch off. On a write, the controller drives the data bus only while WE is low, and it releases the bus one cycle before WE rises. The data bus is split into output, output-enable and input vectors, and the pad cell is placed outside this block.

Top module: `sram_ctl`

## Requirements
- R1: From reset release, the chip stays deselected (CE1_n=1, CE2=0) and no access starts until HOLD_CYC = ceil(T_HOLD_NS/CLK_PERIOD_NS) rising edges have passed. A request held high from reset is taken at rising edge HOLD_CYC+1.
- R2: During reset and whenever no access is in progress, the pins read CE1_n=1, CE2=0, OE_n=1, WE_n=1 and data drive off.
- R3: A read shows CE1_n=0, CE2=1, OE_n=0 and WE_n=1 for exactly RD_CYC = ceil(max(T_RC,T_AA,T_OA)/period) cycles, starting the cycle after acceptance. The requested address stays stable on the address pins throughout.
- R4: The byte on the data input during the last read cycle appears on `rd_data` in the cycle that follows, together with `ack`.
- R5: A write holds WE_n=0 for DRV_CYC+1 cycles, with the chip selected, OE_n=1 and the address stable, where DRV_CYC = max(ceil(T_WP)-1, ceil(T_DS), 1) in cycles.
- R6: The write data is driven (drive enable 1, value equal to the request data) for the first DRV_CYC cycles of the write pulse and released in its final cycle. Drive is never on while OE_n=0 or WE_n=1.
- R7: After the last read cycle, TURN_CYC = ceil(max(T_CE_OFF,T_OE_OFF)/period) cycles follow with the chip deselected and drive off, and no new access starts in them.
- R8: After the write pulse, REC_CYC = max(ceil(T_WC/period) - DRV_CYC - 1, 0) deselected cycles pass before the controller can take the next request.
- R9: `ack` is high for exactly one cycle per access, in the cycle after the final strobe cycle. With `req` held high continuously, each access gets exactly one `ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| req | input | 1 | Access request level |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Write byte |
| ack | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Captured read byte, valid with ack |
| sram_addr | output | 17 | Memory address pins |
| sram_ce1_n | output | 1 | Chip enable, active low |
| sram_ce2 | output | 1 | Chip enable, active high |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_dq_o | output | 8 | Data to the pad |
| sram_dq_oe | output | 1 | Pad drive enable |
| sram_dq_i | input | 8 | Data from the pad |

## Verification
The phase counter and the state register together set every strobe edge. An off-by-one in either shifts an OE, WE or chip-enable edge by a cycle, and the per-cycle comparison of all pin levels shows it within that same cycle. A wrong capture point or a stale data register is seen at the first read `ack`, because each read returns a byte that depends on its address. A hold counter that ends early shows as chip-enable activity before rising edge HOLD_CYC+1. A drive enable left on for one cycle too long shows as drive high in the final WE-low cycle.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_TURN,
    ST_WDRV,
    ST_WEND,
    ST_WREC
  } seq_state_e;

  typedef struct packed {
    logic ce1_n;
    logic ce2;
    logic oe_n;
    logic we_n;
    logic dq_oe;
  } strobe_t;

  localparam strobe_t STROBE_IDLE = '{ce1_n: 1'b1, ce2: 1'b0, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};

  // ceiling of ns / clock period, never below one cycle
  function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    if (c == 0) c = 1;
    return c;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctl_hold.sv
module sram_ctl_hold #(
  parameter int unsigned HOLD_CYC = 625000
) (
  input  logic clk,
  input  logic rst_n,
  output logic hold_done
);
  localparam int unsigned CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] HOLD_V = CW'(HOLD_CYC);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign hold_done = (cnt_q == HOLD_V);
  assign cnt_en    = !hold_done;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_en) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // once the interval has passed it never re-arms without reset
  p_hold_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
    hold_done |=> hold_done);

endmodule

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
  import sram_ctl_pkg::*;
#(
  parameter int unsigned RD_CYC   = 9,
  parameter int unsigned TURN_CYC = 5,
  parameter int unsigned DRV_CYC  = 6,
  parameter int unsigned REC_CYC  = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    hold_done,
  input  logic    req,
  input  logic    req_we,
  output logic    accept,
  output logic    capture,
  output logic    ack,
  output strobe_t pins
);
  localparam int unsigned MAXC = umax(umax(RD_CYC, TURN_CYC), umax(DRV_CYC, umax(REC_CYC, 1)));
  localparam int unsigned CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] RD_LAST   = CW'(RD_CYC - 1);
  localparam logic [CW-1:0] TURN_LAST = CW'(TURN_CYC - 1);
  localparam logic [CW-1:0] DRV_LAST  = CW'(DRV_CYC - 1);
  localparam logic [CW-1:0] REC_LAST  = CW'((REC_CYC > 0) ? REC_CYC - 1 : 0);
  localparam bit            HAS_REC   = (REC_CYC > 0);

  seq_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ack_q, ack_d;
  strobe_t       pins_q, pins_d;
  logic          cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  // next state and phase counter
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    accept  = 1'b0;
    capture = 1'b0;
    ack_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (hold_done && req && !ack_q) begin
          accept = 1'b1;
          if (req_we) begin
            state_d = ST_WDRV;
            cnt_d   = DRV_LAST;
          end else begin
            state_d = ST_RD;
            cnt_d   = RD_LAST;
          end
        end
      end
      ST_RD: begin
        if (cnt_zero) begin
          capture = 1'b1;
          ack_d   = 1'b1;
          state_d = ST_TURN;
          cnt_d   = TURN_LAST;
        end else begin
          cnt_d = cnt_q - CW'(1);
        end
      end
      ST_TURN: begin
        if (cnt_zero) state_d = ST_IDLE;
        else          cnt_d   = cnt_q - CW'(1);
      end
      ST_WDRV: begin
        if (cnt_zero) state_d = ST_WEND;
        else          cnt_d   = cnt_q - CW'(1);
      end
      ST_WEND: begin
        ack_d = 1'b1;
        if (HAS_REC) begin
          state_d = ST_WREC;
          cnt_d   = REC_LAST;
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_WREC: begin
        if (cnt_zero) state_d = ST_IDLE;
        else          cnt_d   = cnt_q - CW'(1);
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // pin levels decoded from the next state, then registered
  always_comb begin
    pins_d = STROBE_IDLE;
    unique case (state_d)
      ST_RD: begin
        pins_d.ce1_n = 1'b0;
        pins_d.ce2   = 1'b1;
        pins_d.oe_n  = 1'b0;
      end
      ST_WDRV: begin
        pins_d.ce1_n = 1'b0;
        pins_d.ce2   = 1'b1;
        pins_d.we_n  = 1'b0;
        pins_d.dq_oe = 1'b1;
      end
      ST_WEND: begin
        pins_d.ce1_n = 1'b0;
        pins_d.ce2   = 1'b1;
        pins_d.we_n  = 1'b0;
      end
      default: pins_d = STROBE_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      ack_q   <= 1'b0;
      pins_q  <= STROBE_IDLE;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      ack_q   <= ack_d;
      pins_q  <= pins_d;
    end
  end

  assign ack  = ack_q;
  assign pins = pins_q;

  p_ack_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |=> !ack_q);

  p_drive_in_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pins_q.dq_oe |-> (pins_q.oe_n && !pins_q.we_n));

  p_drive_off_before_we_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pins_q.we_n) |-> !$past(pins_q.dq_oe));

  p_read_selected_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !pins_q.oe_n |-> (pins_q.we_n && !pins_q.ce1_n && pins_q.ce2));

  p_ack_after_strobes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_q) |-> !$past(pins_q.ce1_n));

endmodule

// File: rtl/sram_ctl_dpath.sv
module sram_ctl_dpath #(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] dq_i,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata_q
);
  logic [ADDR_W-1:0] addr_d;
  logic [DATA_W-1:0] wdata_d;
  logic [DATA_W-1:0] rdata_d;

  always_comb begin
    addr_d  = addr_q;
    wdata_d = wdata_q;
    rdata_d = rdata_q;
    if (accept) begin
      addr_d  = req_addr;
      wdata_d = req_wdata;
    end
    if (capture) rdata_d = dq_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      rdata_q <= rdata_d;
    end
  end

  // the request fields are taken only at acceptance, which never coincides with capture
  p_accept_capture_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept && capture));

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W        = 17,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned CLK_PERIOD_NS = 8,
  parameter int unsigned T_RC_NS       = 70,
  parameter int unsigned T_AA_NS       = 70,
  parameter int unsigned T_OA_NS       = 50,
  parameter int unsigned T_WC_NS       = 70,
  parameter int unsigned T_WP_NS       = 50,
  parameter int unsigned T_DS_NS       = 40,
  parameter int unsigned T_CE_OFF_NS   = 40,
  parameter int unsigned T_OE_OFF_NS   = 35,
  parameter int unsigned T_HOLD_NS     = 5000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ack,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_ce1_n,
  output logic              sram_ce2,
  output logic              sram_oe_n,
  output logic              sram_we_n,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_i
);
  localparam int unsigned RD_CYC   = ns2cyc(umax(T_RC_NS, umax(T_AA_NS, T_OA_NS)), CLK_PERIOD_NS);
  localparam int unsigned TURN_CYC = ns2cyc(umax(T_CE_OFF_NS, T_OE_OFF_NS), CLK_PERIOD_NS);
  localparam int unsigned WP_CYC   = ns2cyc(T_WP_NS, CLK_PERIOD_NS);
  localparam int unsigned DS_CYC   = ns2cyc(T_DS_NS, CLK_PERIOD_NS);
  localparam int unsigned DRV_CYC  = umax(umax(WP_CYC - 1, DS_CYC), 1);
  localparam int unsigned WC_CYC   = ns2cyc(T_WC_NS, CLK_PERIOD_NS);
  localparam int unsigned REC_CYC  = (WC_CYC > DRV_CYC + 1) ? (WC_CYC - DRV_CYC - 1) : 0;
  localparam int unsigned HOLD_CYC = ns2cyc(T_HOLD_NS, CLK_PERIOD_NS);

  logic    hold_done;
  logic    accept;
  logic    capture;
  strobe_t pins;

  sram_ctl_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold_done (hold_done)
  );

  sram_ctl_seq #(
    .RD_CYC   (RD_CYC),
    .TURN_CYC (TURN_CYC),
    .DRV_CYC  (DRV_CYC),
    .REC_CYC  (REC_CYC)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold_done (hold_done),
    .req       (req),
    .req_we    (req_we),
    .accept    (accept),
    .capture   (capture),
    .ack       (ack),
    .pins      (pins)
  );

  sram_ctl_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .capture   (capture),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .dq_i      (sram_dq_i),
    .addr_q    (sram_addr),
    .wdata_q   (sram_dq_o),
    .rdata_q   (rd_data)
  );

  assign sram_ce1_n = pins.ce1_n;
  assign sram_ce2   = pins.ce2;
  assign sram_oe_n  = pins.oe_n;
  assign sram_we_n  = pins.we_n;
  assign sram_dq_oe = pins.dq_oe;

  p_deselect_in_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_done |-> (sram_ce1_n && !sram_ce2 && !sram_dq_oe));

  p_addr_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_ce1_n && $past(!sram_ce1_n)) |-> $stable(sram_addr));

  p_wdata_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_dq_oe && $past(sram_dq_oe)) |-> $stable(sram_dq_o));

endmodule

// File: tb/tb_sram_ctl.sv
module tb_sram_ctl;
  localparam int CLK_NS  = 8;
  localparam int T_RC    = 70, T_AA = 70, T_OA = 50;
  localparam int T_WC    = 72, T_WP = 50, T_DS = 40;
  localparam int T_CEOFF = 40, T_OEOFF = 35, T_HOLD = 400;

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RD   = cyc(mx(T_RC, mx(T_AA, T_OA)));
  localparam int TURN = cyc(mx(T_CEOFF, T_OEOFF));
  localparam int DRV  = mx(mx(cyc(T_WP) - 1, cyc(T_DS)), 1);
  localparam int REC  = mx(cyc(T_WC) - DRV - 1, 0);
  localparam int HOLD = cyc(T_HOLD);

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req, req_we;
  logic [16:0] req_addr;
  logic [7:0]  req_wdata;
  logic        ack;
  logic [7:0]  rd_data;
  logic [16:0] sram_addr;
  logic        sram_ce1_n, sram_ce2, sram_oe_n, sram_we_n, sram_dq_oe;
  logic [7:0]  sram_dq_o;
  logic [7:0]  sram_dq_i;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #(CLK_NS / 2) clk = ~clk;

  sram_ctl #(
    .CLK_PERIOD_NS (CLK_NS),
    .T_RC_NS (T_RC), .T_AA_NS (T_AA), .T_OA_NS (T_OA),
    .T_WC_NS (T_WC), .T_WP_NS (T_WP), .T_DS_NS (T_DS),
    .T_CE_OFF_NS (T_CEOFF), .T_OE_OFF_NS (T_OEOFF), .T_HOLD_NS (T_HOLD)
  ) dut (
    .clk (clk), .rst_n (rst_n), .req (req), .req_we (req_we),
    .req_addr (req_addr), .req_wdata (req_wdata), .ack (ack), .rd_data (rd_data),
    .sram_addr (sram_addr), .sram_ce1_n (sram_ce1_n), .sram_ce2 (sram_ce2),
    .sram_oe_n (sram_oe_n), .sram_we_n (sram_we_n), .sram_dq_o (sram_dq_o),
    .sram_dq_oe (sram_dq_oe), .sram_dq_i (sram_dq_i)
  );

  function automatic logic [7:0] pattern(input int a);
    return 8'(a ^ (a >> 8) ^ (a >> 13) ^ 8'h3C);
  endfunction

  // behavioural memory seen by the pins
  logic [7:0] sram_mem [int];
  function automatic logic [7:0] sram_rd(input int a);
    return sram_mem.exists(a) ? sram_mem[a] : pattern(a);
  endfunction
  always @(posedge clk)
    if (rst_n && !sram_ce1_n && sram_ce2 && !sram_we_n && sram_dq_oe)
      sram_mem[int'(sram_addr)] = sram_dq_o;
  always @(negedge clk)
    sram_dq_i <= (!sram_ce1_n && sram_ce2 && !sram_oe_n && sram_we_n) ? sram_rd(int'(sram_addr)) : 8'h00;

  // reference model: phase = cycle index inside the current access, 0 when idle
  logic [7:0] ref_mem [int];
  int         edges = 0, phase = 0;
  bit         m_we, m_ack = 1'b0, m_rdv = 1'b0, prev_ack;
  logic [16:0] m_addr;
  logic [7:0]  m_data, m_rd;

  always @(posedge clk) begin
    if (!rst_n) begin
      edges = 0; phase = 0; m_ack = 1'b0; m_rdv = 1'b0;
    end else begin
      prev_ack = m_ack;
      m_ack = 1'b0; m_rdv = 1'b0;
      if (phase == 0) begin
        if (edges >= HOLD && req && !prev_ack) begin
          phase = 1; m_we = req_we; m_addr = req_addr; m_data = req_wdata;
        end
      end else if (!m_we) begin
        if (phase == RD) begin
          m_ack = 1'b1; m_rdv = 1'b1;
          m_rd  = ref_mem.exists(int'(m_addr)) ? ref_mem[int'(m_addr)] : pattern(int'(m_addr));
        end
        phase = (phase == RD + TURN) ? 0 : phase + 1;
      end else begin
        if (phase == DRV + 1) begin
          m_ack = 1'b1; ref_mem[int'(m_addr)] = m_data;
        end
        phase = (phase == DRV + 1 + REC) ? 0 : phase + 1;
      end
      edges++;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [4:0] exp_p, act_p;
      string tag;
      bit addr_chk, data_chk;
      exp_p = 5'b10110; addr_chk = 1'b0; data_chk = 1'b0;
      tag = (edges < HOLD + 1) ? "R1" : "R2";
      if (phase != 0 && !m_we) begin
        if (phase <= RD) begin exp_p = 5'b01010; addr_chk = 1'b1; tag = "R3"; end
        else tag = "R7";
      end else if (phase != 0) begin
        if (phase <= DRV) begin exp_p = 5'b01101; addr_chk = 1'b1; data_chk = 1'b1; tag = "R5/R6"; end
        else if (phase == DRV + 1) begin exp_p = 5'b01100; addr_chk = 1'b1; tag = "R6"; end
        else tag = "R8";
      end
      act_p = {sram_ce1_n, sram_ce2, sram_oe_n, sram_we_n, sram_dq_oe};
      tests++;
      if (act_p !== exp_p) begin
        fails++;
        $display("FAIL %s pins {ce1_n,ce2,oe_n,we_n,oe} act=%b exp=%b phase=%0d", tag, act_p, exp_p, phase);
      end
      if (addr_chk && sram_addr !== m_addr) begin
        fails++;
        $display("FAIL %s address act=%h exp=%h", tag, sram_addr, m_addr);
      end
      if (data_chk && sram_dq_o !== m_data) begin
        fails++;
        $display("FAIL R6 write data act=%h exp=%h", sram_dq_o, m_data);
      end
      tests++;
      if (ack !== m_ack) begin
        fails++;
        $display("FAIL R9 ack act=%b exp=%b", ack, m_ack);
      end
      if (m_rdv) begin
        tests++;
        if (rd_data !== m_rd) begin
          fails++;
          $display("FAIL R4 rd_data act=%h exp=%h addr=%h", rd_data, m_rd, m_addr);
        end
      end
    end
  end

  task automatic access(input bit we, input logic [16:0] a, input logic [7:0] d);
    req = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    do @(negedge clk); while (!ack);
    req = 1'b0;
    @(negedge clk);
  endtask

  // request held high throughout; fields change in each ack cycle
  task automatic chain(input int n, input logic [16:0] base);
    for (int i = 0; i < n; i++) begin
      req = 1'b1; req_we = i[0] ? 1'b0 : 1'b1;
      req_addr = base; req_wdata = 8'(8'h40 + i);
      do @(negedge clk); while (!ack);
    end
    req = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    // R1: a read request is pending from reset onward
    req = 1'b1; req_we = 1'b0; req_addr = 17'h00123; req_wdata = 8'h00;
    repeat (3) @(negedge clk);
    tests++;
    if ({sram_ce1_n, sram_ce2, sram_oe_n, sram_we_n, sram_dq_oe, ack} !== 6'b101100) begin
      fails++;
      $display("FAIL R2 reset pins act=%b exp=101100",
               {sram_ce1_n, sram_ce2, sram_oe_n, sram_we_n, sram_dq_oe, ack});
    end
    rst_n = 1'b1;
    do @(negedge clk); while (!ack);
    req = 1'b0;
    @(negedge clk);
    // R5 R6 R4: write then read back, including edge addresses and data values
    access(1'b1, 17'h00010, 8'hA7);
    access(1'b0, 17'h00010, 8'h00);
    access(1'b1, 17'h00000, 8'h00);
    access(1'b1, 17'h1FFFF, 8'hFF);
    access(1'b0, 17'h1FFFF, 8'h00);
    access(1'b0, 17'h00000, 8'h00);
    access(1'b0, 17'h0ABCD, 8'h00);
    repeat (4) @(negedge clk);
    // R7 R8 R9: back-to-back with request held
    chain(6, 17'h15555);
    access(1'b0, 17'h15555, 8'h00);
    repeat (10) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule